// File: doc/BRIEF.md
# Multi-mode 16-bit reload timer

This block is one channel of a reload timer. It holds a counter and a reload register. A mode field picks one of four behaviours:

- **Periodic timer:** counts down on a divided clock enable.
- **Event counter:** counts edges of an external pin, or the overflow strobes of the previous or next channel in a ring. It counts up or down.
- **One-shot:** drives a single output pulse.
- **PWM:** drives a repeating output with a programmed high time and low time.

Every reload event raises an overflow strobe and an interrupt request, each one cycle wide. The neighbouring channels use the overflow strobe as a count source.

Software writes one byte per cycle into a mode register and into the two bytes of the reload register. The write port has no back-pressure: a write is taken in the cycle that `wr_en` is high. The data flow is this write port only. The counting inputs and the outputs are plain control pins. The counter value is brought out as a read path.

Top module: `reload_timer`

## Requirements
- R1: After reset the mode byte, reload value and counter are 0, and `ovf`, `irq` and `out_pin` are low.
- R2: Write address 0 sets the mode byte, address 1 sets reload bits 7:0 and address 2 sets reload bits 15:8. A reload-byte write while `start` is low also loads the whole new reload value into the counter at the same edge.
- R3: A reload-byte write while `start` is high changes only the reload register. The counter keeps counting and takes the new value at its next reload.
- R4: Mode byte bits 1:0 = 00 selects periodic timer mode. In this mode bits 7:6 choose the count enable: 00 = `tick_fast`, 01 = `tick_div8`, 10 = `tick_div32`, 11 = never. On each enable the counter decrements. An enable at count 0 instead reloads the counter, pulses `ovf` high for one cycle on the following cycle, and toggles `out_pin`.
- R5: With mode byte bit 2 set in periodic mode, an enable counts only while the pin level is high.
- R6: Mode byte bit 3 inverts `ext_pin` before the pin is used as a gate or as an edge source.
- R7: Mode bits 1:0 = 01 selects event mode. In this mode bits 7:6 choose the source: 00 = rising edges of the pin level, 10 = `prev_ovf`, 11 = `next_ovf`, 01 = nothing. Reload and toggle follow R4.
- R8: In event mode `count_up` = 1 makes the counter increment, and an enable at FFFFh reloads with an overflow strobe. Outside event mode `count_up` has no effect.
- R9: Mode bits 1:0 = 10 selects one-shot mode. A trigger occurs when:
  - bit 4 = 0: `start` rises;
  - bit 4 = 1: `ext_trig` rises while `start` is high.

  A trigger loads the reload value and raises `out_pin`. After exactly that many enables `out_pin` falls, together with one overflow strobe. A trigger while the pulse runs, or with reload 0, is ignored.
- R10: Mode bits 1:0 = 11 selects PWM mode. The same trigger as R9 starts a high phase. The high phase lasts reload[15:8] enables and the low phase lasts reload[7:0] enables; the two phases repeat, and a field of 0 lasts one enable. An overflow strobe marks the end of each low phase.
- R11: While `start` is low the counter holds its value and no overflow strobe occurs.
- R12: `irq` equals `ovf` in every cycle.
- R13: A mode-byte write clears `out_pin`, ends a running one-shot pulse, and performs no count in its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 2 | 0 = mode byte, 1 = reload low, 2 = reload high |
| wr_data | input | 8 | Write data byte |
| start | input | 1 | Run enable |
| count_up | input | 1 | Count direction in event mode |
| tick_fast | input | 1 | Undivided count enable |
| tick_div8 | input | 1 | Count enable divided by 8 |
| tick_div32 | input | 1 | Count enable divided by 32 |
| ext_pin | input | 1 | External count or gate pin |
| ext_trig | input | 1 | External one-shot / PWM trigger |
| prev_ovf | input | 1 | Overflow strobe of the previous channel |
| next_ovf | input | 1 | Overflow strobe of the next channel |
| count | output | 16 | Current counter value |
| ovf | output | 1 | One-cycle overflow/underflow strobe |
| irq | output | 1 | One-cycle interrupt request |
| out_pin | output | 1 | Toggle or pulse output |

## Verification
The hardest state to reach from the ports is the up-count wrap at FFFFh. At 16 bits it would take tens of thousands of enables. The stimulus avoids this by preloading FFFCh through a stopped reload write and then feeding dense neighbour strobes. The second hard case is a one-shot retrigger that lands while a pulse is running. To reach it, the external trigger is pulsed at random while short pulses run. A behavioural model tracks every mode under random pin and strobe noise, so inputs that should be ignored are checked on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_PERIODIC = 2'b00,
    MD_EVENT    = 2'b01,
    MD_ONESHOT  = 2'b10,
    MD_PWM      = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic [1:0] src;
    logic       spare;
    logic       trig_ext;
    logic       pin_inv;
    logic       gate_en;
    tmr_mode_e  mode;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output tmr_cfg_t      cfg_q,
  output logic          cfg_wr,
  output logic [CW-1:0] reload_q,
  output logic [CW-1:0] reload_nx,
  output logic          reload_wr
);
  localparam int NB = CW / 8;

  logic [NB-1:0] byte_hit;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign byte_hit[b] = wr_en && (wr_addr == AW'(b + 1));
      assign reload_nx[b*8 +: 8] = byte_hit[b] ? wr_data : reload_q[b*8 +: 8];
    end
  endgenerate

  assign cfg_wr    = wr_en && (wr_addr == '0);
  assign reload_wr = |byte_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      reload_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= tmr_cfg_t'(wr_data);
      reload_q <= reload_nx;
    end
  end
endmodule

// File: rtl/tmr_src.sv
module tmr_src
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  tmr_cfg_t cfg,
  input  logic     start,
  input  logic     tick_fast,
  input  logic     tick_div8,
  input  logic     tick_div32,
  input  logic     ext_pin,
  input  logic     ext_trig,
  input  logic     prev_ovf,
  input  logic     next_ovf,
  output logic     tick,
  output logic     trig
);
  logic pin_lvl, pin_q, trig_q, start_q, base;

  assign pin_lvl = ext_pin ^ cfg.pin_inv;

  always_comb begin
    base = 1'b0;
    if (cfg.mode == MD_EVENT) begin
      case (cfg.src)
        2'b00:   base = pin_lvl & ~pin_q;
        2'b10:   base = prev_ovf;
        2'b11:   base = next_ovf;
        default: base = 1'b0;
      endcase
    end else begin
      case (cfg.src)
        2'b00:   base = tick_fast;
        2'b01:   base = tick_div8;
        2'b10:   base = tick_div32;
        default: base = 1'b0;
      endcase
      if (cfg.mode == MD_PERIODIC && cfg.gate_en) base = base & pin_lvl;
    end
  end

  assign tick = start & base;
  assign trig = start & (cfg.trig_ext ? (ext_trig & ~trig_q) : ~start_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      trig_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      pin_q   <= pin_lvl;
      trig_q  <= ext_trig;
      start_q <= start;
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_mode_e     mode,
  input  logic          count_up,
  input  logic          tick,
  input  logic          trig,
  input  logic          cfg_wr,
  input  logic          reload_wr,
  input  logic          start,
  input  logic [CW-1:0] reload_q,
  input  logic [CW-1:0] reload_nx,
  output logic [CW-1:0] cnt_q,
  output logic          out_q,
  output logic          ovf_q
);
  localparam int HW = CW / 2;
  localparam logic [CW-1:0] ALL1 = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          busy_q, busy_d, out_d, ovf_d, up, wrap;
  logic [CW-1:0] cnt_d, hi_ph, lo_ph;

  assign up    = (mode == MD_EVENT) & count_up;
  assign wrap  = up ? (cnt_q == ALL1) : (cnt_q == '0);
  assign hi_ph = {{HW{1'b0}}, reload_q[CW-1:HW]};
  assign lo_ph = {{HW{1'b0}}, reload_q[HW-1:0]};

  always_comb begin
    cnt_d  = cnt_q;
    out_d  = out_q;
    busy_d = busy_q;
    ovf_d  = 1'b0;
    if (cfg_wr) begin
      out_d  = 1'b0;
      busy_d = 1'b0;
    end else begin
      case (mode)
        MD_PERIODIC, MD_EVENT: begin
          if (tick) begin
            if (wrap) begin
              cnt_d = reload_q;
              ovf_d = 1'b1;
              out_d = ~out_q;
            end else begin
              cnt_d = up ? cnt_q + ONE : cnt_q - ONE;
            end
          end
        end
        MD_ONESHOT: begin
          if (trig && !busy_q) begin
            if (reload_q != '0) begin
              cnt_d  = reload_q;
              busy_d = 1'b1;
              out_d  = 1'b1;
            end
          end else if (tick && busy_q) begin
            if (cnt_q <= ONE) begin
              cnt_d  = reload_q;
              busy_d = 1'b0;
              out_d  = 1'b0;
              ovf_d  = 1'b1;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        MD_PWM: begin
          if (trig) begin
            cnt_d = hi_ph;
            out_d = 1'b1;
          end else if (tick) begin
            if (cnt_q <= ONE) begin
              if (out_q) begin
                out_d = 1'b0;
                cnt_d = lo_ph;
              end else begin
                out_d = 1'b1;
                cnt_d = hi_ph;
                ovf_d = 1'b1;
              end
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
      endcase
    end
    if (reload_wr && !start) cnt_d = reload_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      out_q  <= 1'b0;
      busy_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      busy_q <= busy_d;
      ovf_q  <= ovf_d;
    end
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import tmr_pkg::*;
#(
  parameter int CW = 16,
  localparam int AW = $clog2(CW / 8 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          start,
  input  logic          count_up,
  input  logic          tick_fast,
  input  logic          tick_div8,
  input  logic          tick_div32,
  input  logic          ext_pin,
  input  logic          ext_trig,
  input  logic          prev_ovf,
  input  logic          next_ovf,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          irq,
  output logic          out_pin
);
  tmr_cfg_t      cfg_q;
  logic          cfg_wr, reload_wr, tick, trig;
  logic [CW-1:0] reload_q, reload_nx;

  tmr_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_q(cfg_q), .cfg_wr(cfg_wr),
    .reload_q(reload_q), .reload_nx(reload_nx), .reload_wr(reload_wr)
  );

  tmr_src u_src (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .start(start),
    .tick_fast(tick_fast), .tick_div8(tick_div8), .tick_div32(tick_div32),
    .ext_pin(ext_pin), .ext_trig(ext_trig), .prev_ovf(prev_ovf),
    .next_ovf(next_ovf), .tick(tick), .trig(trig)
  );

  tmr_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(cfg_q.mode), .count_up(count_up),
    .tick(tick), .trig(trig), .cfg_wr(cfg_wr), .reload_wr(reload_wr),
    .start(start), .reload_q(reload_q), .reload_nx(reload_nx),
    .cnt_q(count), .out_q(out_pin), .ovf_q(ovf)
  );

  assign irq = ovf;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input tmr_cfg_t      cfg,
  input logic [CW-1:0] count,
  input logic          count_up,
  input logic          ovf,
  input logic          out_pin
);
  assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !wr_en) |=> ($stable(count) && !ovf));

  assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_en && cfg.mode == MD_PERIODIC)
      |=> (ovf || $stable(count) || count == $past(count) - CW'(1)));

  assert_up_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_en && cfg.mode == MD_EVENT && count_up)
      |=> (ovf || $stable(count) || count == $past(count) + CW'(1)));

  assert_pulse_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MD_ONESHOT && !wr_en && out_pin) |=> (out_pin || ovf));

  assert_cfg_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |=> !out_pin);
endmodule

bind reload_timer tmr_checker #(.CW(CW), .AW($clog2(CW / 8 + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
  .cfg(cfg_q), .count(count), .count_up(count_up), .ovf(ovf), .out_pin(out_pin)
);

// File: tb/reload_timer_bench.sv
`timescale 1ns/1ps
module reload_timer_bench;
  localparam int T = 20;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0, count_up = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic tick_fast = 0, tick_div8 = 0, tick_div32 = 0;
  logic ext_pin = 0, ext_trig = 0, prev_ovf = 0, next_ovf = 0;
  logic [15:0] count;
  logic ovf, irq, out_pin;

  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";
  bit done = 0;

  reload_timer u_reload_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .count_up(count_up), .tick_fast(tick_fast),
    .tick_div8(tick_div8), .tick_div32(tick_div32), .ext_pin(ext_pin),
    .ext_trig(ext_trig), .prev_ovf(prev_ovf), .next_ovf(next_ovf),
    .count(count), .ovf(ovf), .irq(irq), .out_pin(out_pin)
  );

  always #(T/2) clk = ~clk;

  // reference model state
  int m_cnt, m_rel, m_cfg;
  bit m_out, m_busy, m_ovf, m_pinq, m_trq, m_stq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_cfg = 0;
      m_out = 0; m_busy = 0; m_ovf = 0; m_pinq = 0; m_trq = 0; m_stq = 0;
    end else begin
      bit pol, base, tk, tg, up, nov;
      int md, sb, nrel;
      md  = m_cfg & 3;
      sb  = (m_cfg >> 6) & 3;
      pol = ext_pin ^ m_cfg[3];
      if (md == 1) base = (sb == 0) ? (pol && !m_pinq) : (sb == 2) ? prev_ovf : (sb == 3) ? next_ovf : 0;
      else begin
        base = (sb == 0) ? tick_fast : (sb == 1) ? tick_div8 : (sb == 2) ? tick_div32 : 0;
        if (md == 0 && m_cfg[2]) base = base && pol;
      end
      tk  = start && base;
      tg  = start && (m_cfg[4] ? (ext_trig && !m_trq) : !m_stq);
      up  = (md == 1) && count_up;
      nov = 0;
      if (wr_en && wr_addr == 0) begin
        m_out = 0; m_busy = 0;
      end else if (md <= 1) begin
        if (tk) begin
          if (up ? (m_cnt == 65535) : (m_cnt == 0)) begin
            m_cnt = m_rel; nov = 1; m_out = !m_out;
          end else m_cnt = up ? m_cnt + 1 : m_cnt - 1;
        end
      end else if (md == 2) begin
        if (tg && !m_busy) begin
          if (m_rel != 0) begin m_cnt = m_rel; m_busy = 1; m_out = 1; end
        end else if (tk && m_busy) begin
          if (m_cnt <= 1) begin m_cnt = m_rel; m_busy = 0; m_out = 0; nov = 1; end
          else m_cnt = m_cnt - 1;
        end
      end else begin
        if (tg) begin m_cnt = m_rel >> 8; m_out = 1; end
        else if (tk) begin
          if (m_cnt <= 1) begin
            if (m_out) begin m_out = 0; m_cnt = m_rel & 255; end
            else begin m_out = 1; m_cnt = m_rel >> 8; nov = 1; end
          end else m_cnt = m_cnt - 1;
        end
      end
      nrel = m_rel;
      if (wr_en && wr_addr == 1) nrel = (m_rel & 16'hFF00) | wr_data;
      if (wr_en && wr_addr == 2) nrel = (m_rel & 16'h00FF) | (int'(wr_data) << 8);
      if (wr_en && (wr_addr == 1 || wr_addr == 2) && !start) m_cnt = nrel;
      m_rel = nrel;
      if (wr_en && wr_addr == 0) m_cfg = wr_data;
      m_pinq = pol; m_trq = ext_trig; m_stq = start;
      m_ovf = nov;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (count !== 16'(m_cnt) || ovf !== m_ovf || irq !== m_ovf || out_pin !== m_out) begin
        bad++;
        $display("FAIL %s cyc=%0d count=%h/%h ovf=%b/%b irq=%b out=%b/%b (actual/expected)",
                 tag, cyc, count, 16'(m_cnt), ovf, m_ovf, irq, out_pin, m_out);
      end
    end
  end

  // enable generation and background noise
  always @(posedge clk) begin
    #1;
    cyc++;
    tick_fast  = (cyc % 2 == 0);
    tick_div8  = (cyc % 8 == 0);
    tick_div32 = (cyc % 32 == 0);
    if ($urandom_range(3) == 0) ext_pin = ~ext_pin;
    prev_ovf = ($urandom_range(2) == 0);
    next_ovf = ($urandom_range(3) == 0);
    ext_trig = ($urandom_range(9) == 0);
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic set_start(input bit s);
    @(posedge clk); #2; start = s;
  endtask

  initial begin
    fork
      begin
        #(T * 150000);
        bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    idle(3);
    #2 rst_n = 1;
    idle(1);
    tag = "R1";
    chk("R1 count", count, 0);
    chk("R1 out", out_pin, 0);
    chk("R1 ovf", ovf, 0);

    tag = "R2";
    wr(0, 8'h00);
    wr(1, 8'h05); wr(2, 8'h00);
    idle(1);
    chk("R2 stopped load", count, 5);

    tag = "R11";
    idle(40);
    chk("R11 held", count, 5);

    tag = "R4";
    set_start(1);
    idle(60);
    wr(0, 8'h40); idle(100);
    wr(0, 8'h80); idle(200);
    wr(0, 8'hC0); idle(20);

    tag = "R3";
    wr(0, 8'h00);
    wr(1, 8'h03);
    idle(40);

    tag = "R5";
    wr(0, 8'h04); idle(120);
    tag = "R6";
    wr(0, 8'h0C); idle(120);

    tag = "R7";
    set_start(0);
    wr(1, 8'h09); wr(2, 8'h00);
    set_start(1);
    wr(0, 8'h01); idle(100);
    wr(0, 8'h09); idle(60);
    wr(0, 8'h81); idle(100);
    wr(0, 8'hC1); idle(100);
    wr(0, 8'h41); idle(30);

    tag = "R8";
    set_start(0);
    wr(1, 8'hFC); wr(2, 8'hFF);
    count_up = 1;
    set_start(1);
    wr(0, 8'h81); idle(40);
    set_start(0);
    idle(1);
    chk("R8 wrapped to reload region", (count >= 16'hFFFC) ? 1 : 0, 1);
    wr(0, 8'h00);
    set_start(1); idle(60);
    count_up = 0;

    tag = "R9";
    set_start(0);
    wr(1, 8'h04); wr(2, 8'h00);
    wr(0, 8'h02);
    set_start(1);
    idle(30);
    set_start(0); set_start(1);
    idle(30);
    wr(0, 8'h12); idle(300);
    set_start(0);
    wr(1, 8'h00);
    set_start(1);
    wr(0, 8'h02); idle(20);
    chk("R9 zero reload ignored", out_pin, 0);

    tag = "R13";
    set_start(0);
    wr(1, 8'h20);
    set_start(1);
    idle(6);
    chk("R13 pulse running", out_pin, 1);
    wr(0, 8'h02);
    chk("R13 cleared", out_pin, 0);
    idle(20);

    tag = "R10";
    set_start(0);
    wr(1, 8'h02); wr(2, 8'h03);
    wr(0, 8'h03);
    set_start(1);
    idle(80);
    set_start(0);
    wr(1, 8'h00); wr(2, 8'h00);
    set_start(1); idle(30);
    wr(0, 8'h13); idle(120);

    tag = "R12";
    wr(0, 8'h00);
    set_start(0);
    wr(1, 8'h00);
    set_start(1);
    idle(40);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule